// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered picture lines and pulls an active-low CPU interrupt line when a programmed number of lines has gone by. The CPU programs it through a small bank of eight write-only register selects; four of them act on the counter (load, acknowledge and two identical re-arm selects), and the other four are accepted but change nothing. The picture side supplies a one-cycle pulse per line, a blanking indicator and two rendering-enable bits. The block does not derive the line pulse itself.

The counter is 8 bits wide and is read as a signed number. A load write stores the value in both the counter and a reload latch and arms the interrupt. Each qualified line pulse decrements the counter. When an armed counter would reach zero or a negative value, the interrupt fires. Firing disarms the block, zeroes the latch and parks the counter at zero. A re-arm write either reloads the counter from the latch and arms again, or only disarms. Which of the two happens depends on whether the last loaded value was zero. The interrupt line stays low until it is acknowledged or the block is reset.

Top module: `line_irq_unit`

## Requirements
- R1: After reset, and after any later reset, `irq_n` is high. The block is disarmed and the counter, the latch and the last loaded value are all zero.
- R2: A write with `cpu_sel` = 5 loads value N into the counter and the latch and arms the block. For N from 2 to 127, the interrupt fires on the N-th qualified line pulse after the write.
- R3: A write with `cpu_sel` = 2 releases `irq_n` at the next clock edge and disarms the block. Later pulses do not fire until the block is armed again.
- R4: A write with `cpu_sel` = 3 or 4 reloads the counter from the latch and arms the block, provided the last value written with select 5 was nonzero. Because firing zeroes the latch, a re-arm after a fire then fires on the first qualified pulse.
- R5: A write with `cpu_sel` = 3 or 4 only disarms the block if the last value written with select 5 was zero, or if there has been no such write since reset.
- R6: A line pulse counts only when `vblank` is low and at least one of `bg_on` and `spr_on` is high. Any other pulse leaves the counter unchanged.
- R7: When an armed counter holding a signed value of 1 or less receives a qualified pulse, `irq_n` goes low after that clock edge. That edge also disarms the block, zeroes the latch and sets the counter to zero. Loaded values of 0, 1 and 128 to 255 therefore fire on the first pulse.
- R8: Once low, `irq_n` stays low through any number of further pulses and non-acknowledge writes. Only a select-2 write or reset raises it.
- R9: Writes with `cpu_sel` = 0, 1, 6 or 7 have no effect on the counter, the latch, the armed state or `irq_n`.
- R10: A line pulse that arrives in the same cycle as any CPU write is dropped. The write takes effect and the counter does not step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_sel | input | 3 | Register select of the write (0 to 7) |
| cpu_wdata | input | 8 | Write data |
| line_pulse | input | 1 | One-cycle pulse per picture line |
| vblank | input | 1 | High while the line is outside the visible area |
| bg_on | input | 1 | Background rendering enabled |
| spr_on | input | 1 | Sprite rendering enabled |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The counting path is driven with plain positive loads, with loads of zero, one and values whose top bit is set, and with pulse trains in which blanked lines and lines without rendering are mixed among counted ones. These patterns separate an off-by-one in the firing point from a wrong signed comparison and from a faulty pulse qualifier. Re-arm writes are issued before a fire, after a fire and after a zero load, which tells a reload from the latch apart from a reload of the last written value and from a plain disarm. Writes to the ignored selects and writes that coincide with a pulse show whether a write leaks into the count.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

  localparam int unsigned SEL_ACK     = 2;
  localparam int unsigned SEL_REARM_A = 3;
  localparam int unsigned SEL_REARM_B = 4;
  localparam int unsigned SEL_LOAD    = 5;

  typedef struct packed {
    logic load;
    logic ack;
    logic rearm;
  } irq_cmd_t;

  // A line is counted only when visible and something is being drawn.
  function automatic logic line_counts(input logic pulse, input logic blank,
                                       input logic bg, input logic spr);
    return pulse && !blank && (bg || spr);
  endfunction

endpackage

// File: rtl/line_irq_decode.sv
module line_irq_decode
  import line_irq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  output irq_cmd_t         cmd
);

  logic hit_load, hit_ack, hit_rearm;

  assign hit_load  = (wr_sel == SEL_W'(SEL_LOAD));
  assign hit_ack   = (wr_sel == SEL_W'(SEL_ACK));
  assign hit_rearm = (wr_sel == SEL_W'(SEL_REARM_A)) || (wr_sel == SEL_W'(SEL_REARM_B));

  always_comb begin
    cmd       = '0;
    cmd.load  = wr_en && hit_load;
    cmd.ack   = wr_en && hit_ack;
    cmd.rearm = wr_en && hit_rearm;
  end

  // R9: at most one command per write; the spare selects raise none
  p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.load, cmd.ack, cmd.rearm}));

endmodule

// File: rtl/line_irq_core.sv
module line_irq_core
  import line_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_cmd_t         cmd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  input  logic             busy,
  output logic             fire,
  output logic             armed
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] latch;
  logic             last_zero;
  logic             step;

  // Signed value of 1 or less: one more line brings it to zero or below.
  function automatic logic at_floor(input logic [CNT_W-1:0] c);
    return $signed(c) < $signed(TWO);
  endfunction

  function automatic logic above_zero(input logic [CNT_W-1:0] c);
    return $signed(c) > $signed(ZERO);
  endfunction

  // Disarmed counting stops at zero; armed counting never reaches it here.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic arm);
    if (arm || above_zero(c)) return c - ONE;
    return c;
  endfunction

  assign step = tick && !busy;
  assign fire = step && armed && at_floor(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      latch     <= '0;
      armed     <= 1'b0;
      last_zero <= 1'b1;
    end else if (cmd.load) begin
      count     <= wr_data;
      latch     <= wr_data;
      armed     <= 1'b1;
      last_zero <= (wr_data == ZERO);
    end else if (cmd.ack) begin
      armed <= 1'b0;
    end else if (cmd.rearm) begin
      if (last_zero) begin
        armed <= 1'b0;
      end else begin
        armed <= 1'b1;
        count <= latch;
      end
    end else if (fire) begin
      armed <= 1'b0;
      latch <= '0;
      count <= '0;
    end else if (step) begin
      count <= next_count(count, armed);
    end
  end

  // R2: a load arms and places the written value in the counter
  p_load_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> armed && (count == $past(wr_data)) && (latch == $past(wr_data)));

  // R4: re-arm after a nonzero load copies the latch
  p_rearm_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rearm && !last_zero) |=> armed && (count == $past(latch)));

  // R5: re-arm after a zero load only disarms
  p_rearm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rearm && last_zero) |=> !armed);

  // R6: with no counted line and no command, nothing moves
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmd.load && !cmd.ack && !cmd.rearm) |=> $stable(count) && $stable(latch) && $stable(armed));

  // R7: firing disarms and empties the latch
  p_fire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed && (latch == ZERO) && (count == ZERO));

  // R10: a write cycle never steps the counter into a fire
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);

endmodule

// File: rtl/line_irq_line.sv
module line_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic irq_n
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    irq_q <= 1'b0;
    else if (ack)  irq_q <= 1'b0;
    else if (fire) irq_q <= 1'b1;
  end

  assign irq_n = !irq_q;

  // R8: a pending request holds until acknowledged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);

  // R3: acknowledge releases the line
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_q);

  // R7: a fire pulls the line low at the next edge
  p_fire_asserts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ack) |=> !irq_n);

endmodule

// File: rtl/line_irq_unit.sv
module line_irq_unit
  import line_irq_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [SEL_W-1:0] cpu_sel,
  input  logic [CNT_W-1:0] cpu_wdata,
  input  logic             line_pulse,
  input  logic             vblank,
  input  logic             bg_on,
  input  logic             spr_on,
  output logic             irq_n
);

  irq_cmd_t cmd;
  logic     line_tick;
  logic     fire;
  logic     armed;

  assign line_tick = line_counts(line_pulse, vblank, bg_on, spr_on);

  line_irq_decode #(.SEL_W(SEL_W)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cpu_wr),
    .wr_sel (cpu_sel),
    .cmd    (cmd)
  );

  line_irq_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .wr_data (cpu_wdata),
    .tick    (line_tick),
    .busy    (cpu_wr),
    .fire    (fire),
    .armed   (armed)
  );

  line_irq_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .ack   (cmd.ack),
    .irq_n (irq_n)
  );

  // R7: only an armed block can pull the line low
  p_fire_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_n)) |-> $past(armed));

  // R1: the line is released while reset is held
  p_reset_release_r1: assert property (@(posedge clk)
    !rst_n |=> irq_n);

endmodule

// File: tb/line_irq_unit_test.sv
`timescale 1ns/1ps
module line_irq_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [2:0] cpu_sel = '0;
  logic [7:0] cpu_wdata = '0;
  logic       line_pulse = 1'b0;
  logic       vblank = 1'b0;
  logic       bg_on = 1'b0;
  logic       spr_on = 1'b0;
  logic       irq_n;

  always #2 clk = ~clk;

  line_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .line_pulse(line_pulse), .vblank(vblank),
    .bg_on(bg_on), .spr_on(spr_on), .irq_n(irq_n)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Requirement-level model of the block
  int m_cnt, m_lat;
  bit m_arm, m_irq, m_lastz;

  task automatic model_reset();
    m_cnt = 0; m_lat = 0; m_arm = 0; m_irq = 0; m_lastz = 1;
  endtask

  function automatic int as_signed(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic step(input logic wr, input logic [2:0] sel, input logic [7:0] d,
                      input logic pl, input logic bl, input logic bg, input logic sp,
                      input string tag);
    @(posedge clk); #1;
    cpu_wr = wr; cpu_sel = sel; cpu_wdata = d;
    line_pulse = pl; vblank = bl; bg_on = bg; spr_on = sp;
    if (wr) begin
      if (sel == 3'd5) begin
        m_arm = 1; m_lat = d; m_cnt = d; m_lastz = (d == 0);
      end else if (sel == 3'd2) begin
        m_arm = 0; m_irq = 0;
      end else if (sel == 3'd3 || sel == 3'd4) begin
        if (m_lastz) m_arm = 0;
        else begin m_arm = 1; m_cnt = m_lat; end
      end
    end else if (pl && !bl && (bg || sp)) begin
      if (m_arm) begin
        if (as_signed(m_cnt) - 1 <= 0) begin
          m_irq = 1; m_arm = 0; m_lat = 0; m_cnt = 0;
        end else m_cnt = m_cnt - 1;
      end else if (as_signed(m_cnt) > 0) m_cnt = m_cnt - 1;
    end
    q.push_back('{exp: !m_irq, tag: tag});
  endtask

  task automatic idle(input string tag);
    step(0, 3'd0, 8'h00, 0, 0, 0, 0, tag);
  endtask

  task automatic write(input logic [2:0] sel, input logic [7:0] d, input string tag);
    step(1, sel, d, 0, 0, 0, 0, tag);
  endtask

  task automatic lines(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 3'd0, 8'h00, 1, 0, 1, 0, tag);
  endtask

  task automatic drain();
    idle("idle");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    drain();
    @(posedge clk); #1;
    rst_n = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (irq_n !== 1'b1) begin
      fails++;
      $display("FAIL %s: irq_n after reset actual=%b expected=1", tag, irq_n);
    end
  endtask

  // Monitor: compares one expected level per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        @(negedge clk);
        checks++;
        if (irq_n !== it.exp) begin
          fails++;
          $display("FAIL %s: irq_n actual=%b expected=%b", it.tag, irq_n, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset("R1 initial");

    // R2 / R7 / R8 / R3: load 3, fire on third line, hold, acknowledge
    write(3'd5, 8'd3, "R2 load");
    lines(3, "R2 count to fire");
    lines(4, "R8 hold through lines");
    write(3'd0, 8'h11, "R8 hold through write");
    write(3'd2, 8'h00, "R3 ack");
    lines(3, "R3 disarmed after ack");
    drain();

    // R3: acknowledge before fire disarms
    write(3'd5, 8'd3, "R3 load");
    lines(1, "R3 one line");
    write(3'd2, 8'h00, "R3 early ack");
    lines(6, "R3 no fire");
    drain();

    // R6: qualifier
    write(3'd5, 8'd2, "R6 load");
    step(0, 3'd0, 8'h00, 1, 1, 1, 1, "R6 blank line");
    step(0, 3'd0, 8'h00, 1, 0, 0, 0, "R6 render off");
    step(0, 3'd0, 8'h00, 1, 1, 0, 1, "R6 blank sprite");
    step(0, 3'd0, 8'h00, 0, 0, 1, 1, "R6 no pulse");
    step(0, 3'd0, 8'h00, 1, 0, 0, 1, "R6 sprite only");
    step(0, 3'd0, 8'h00, 1, 0, 1, 0, "R6 background only fires");
    write(3'd2, 8'h00, "R3 ack");
    drain();

    // R4: re-arm before fire reloads latch
    write(3'd5, 8'd5, "R4 load");
    lines(2, "R4 partial");
    write(3'd3, 8'hff, "R4 rearm A");
    lines(5, "R4 full reload");
    // latch now zero: re-arm fires on first line
    write(3'd2, 8'h00, "R3 ack");
    write(3'd4, 8'h00, "R4 rearm B after fire");
    lines(1, "R4 fires at once");
    write(3'd2, 8'h00, "R3 ack");
    drain();

    // R5 and R7 corner loads
    write(3'd5, 8'd0, "R5 load zero");
    write(3'd3, 8'h00, "R5 rearm disarms");
    lines(4, "R5 no fire");
    write(3'd5, 8'd0, "R7 load zero");
    lines(1, "R7 zero fires first line");
    write(3'd2, 8'h00, "R3 ack");
    write(3'd5, 8'd1, "R7 load one");
    lines(1, "R7 one fires first line");
    write(3'd2, 8'h00, "R3 ack");
    write(3'd5, 8'h90, "R7 load negative");
    lines(1, "R7 negative fires first line");
    write(3'd2, 8'h00, "R3 ack");
    write(3'd5, 8'd127, "R2 load max");
    lines(127, "R2 count 127");
    write(3'd2, 8'h00, "R3 ack");
    drain();

    // R9: spare selects ignored
    write(3'd5, 8'd4, "R9 load");
    write(3'd0, 8'd1, "R9 sel0");
    write(3'd1, 8'd0, "R9 sel1");
    write(3'd6, 8'd9, "R9 sel6");
    write(3'd7, 8'd0, "R9 sel7");
    lines(4, "R9 count unchanged");
    write(3'd2, 8'h00, "R3 ack");
    drain();

    // R10: pulse during a write is dropped
    write(3'd5, 8'd3, "R10 load");
    step(1, 3'd0, 8'h00, 1, 0, 1, 1, "R10 pulse with write");
    step(1, 3'd7, 8'h00, 1, 0, 1, 0, "R10 pulse with write");
    lines(3, "R10 full count");
    drain();

    // R1: reset with the line low, then re-arm disarms
    do_reset("R1 reset clears irq");
    write(3'd4, 8'h00, "R1 rearm after reset");
    lines(3, "R1 still idle");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule